// File: doc/BRIEF.md
# Storage Controller Interrupt Aggregator

This block collects the event and status conditions of a disk-interface controller into one 8-bit status register. It pairs that register with an enable register and a write-one-to-clear register. Some status bits are live copies of controller signals: the device interrupt line and the protocol-engine idle flag. Two bits are sticky and latch one-cycle FIFO overflow and underflow pulses until software clears them.

The block drives two requests. The CPU interrupt request is the registered OR of every enabled CPU-routed status bit. The DMA end-of-transfer request comes from the top status bit alone. Software reaches the three registers through a simple single-cycle register port with a combinational read path.

Top module: `stor_irq_agg`

## Requirements
- R1: Status bit 7 and status bit 3 both equal the level `dev_irq` had at the previous clock edge, and writing the clear register never changes them.
- R2: `dma_req` is high exactly when status bit 7 and enable bit 7 are both 1, and status bit 7 never causes `cpu_irq`.
- R3: Status bits 6 (underflow) and 5 (overflow) set on a `fifo_unf_pulse` / `fifo_ovf_pulse` cycle and hold until a write to the clear register (address 2) carries 1 in the same bit position.
- R4: Status bit 4 equals the level `eng_idle` had at the previous clock edge, reads 1 after reset, and ignores the clear register.
- R5: When a sticky event and a clear of the same bit happen in the same cycle, the bit ends up set.
- R6: `cpu_irq` equals, one clock later, the OR over bits 6..3 of (status AND enable).
- R7: The status register (address 0) is read-only, so a write to address 0 changes no register.
- R8: Bits 2..0 of status and enable always read 0, and writes to those enable bits are ignored.
- R9: After reset the enable register is 0x00, the sticky bits are 0 and `cpu_irq` is 0. Status bits 7 and 3 reflect `dev_irq` as it was held during reset, so status reads 0x98 with `dev_irq` high and 0x10 with it low.
- R10: The read port returns status at address 0, enable at address 1, and 0x00 at addresses 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | 1 | Device interrupt line level |
| eng_idle | input | 1 | Protocol engine idle, no bus activity |
| fifo_ovf_pulse | input | 1 | One-cycle FIFO overflow event |
| fifo_unf_pulse | input | 1 | One-cycle FIFO underflow event |
| reg_addr | input | 2 | Register address: 0 status, 1 enable, 2 clear |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| cpu_irq | output | 1 | CPU interrupt request |
| dma_req | output | 1 | DMA end-of-transfer request |

## Verification
The main sweep runs all 32 settings of the writable enable bits against all 16 combinations of device interrupt, idle, underflow and overflow. This exposes any bit routed to the wrong output, including bit 7 leaking into the CPU request or any CPU-routed bit reaching the DMA request. Separate sequences apply reset with the device line both high and low, to separate the line-following bits from reset-valued ones. Further sequences collide a clear with a sticky event in the same cycle and write all ones to the clear, status and reserved positions, which shows which bits are live, sticky or fixed at zero.

// File: rtl/stor_irq_agg.sv
module stor_irq_agg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dev_irq,
  input  logic       eng_idle,
  input  logic       fifo_ovf_pulse,
  input  logic       fifo_unf_pulse,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       cpu_irq,
  output logic       dma_req
);
  localparam logic [1:0] ADDR_STAT = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_CLR  = 2'd2;
  localparam logic [7:0] EN_MASK   = 8'hF8;
  localparam logic [7:0] CPU_MASK  = 8'h78;
  localparam int         B_UNF     = 6;
  localparam int         B_OVF     = 5;

  logic       irq_q, idle_q, unf_q, ovf_q, cpu_q;
  logic [7:0] en_q, stat;

  wire wr_en  = reg_wr && (reg_addr == ADDR_EN);
  wire wr_clr = reg_wr && (reg_addr == ADDR_CLR);

  assign stat = {irq_q, unf_q, ovf_q, idle_q, irq_q, 3'b000};

  always_ff @(posedge clk) irq_q <= dev_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b1;
      unf_q  <= 1'b0;
      ovf_q  <= 1'b0;
      en_q   <= 8'h00;
      cpu_q  <= 1'b0;
    end else begin
      idle_q <= eng_idle;
      unf_q  <= fifo_unf_pulse | (unf_q & ~(wr_clr & reg_wdata[B_UNF]));
      ovf_q  <= fifo_ovf_pulse | (ovf_q & ~(wr_clr & reg_wdata[B_OVF]));
      if (wr_en) en_q <= reg_wdata & EN_MASK;
      cpu_q  <= |(stat & en_q & CPU_MASK);
    end
  end

  assign cpu_irq = cpu_q;
  assign dma_req = stat[7] & en_q[7];

  always_comb begin
    case (reg_addr)
      ADDR_STAT: reg_rdata = stat;
      ADDR_EN:   reg_rdata = en_q;
      default:   reg_rdata = 8'h00;
    endcase
  end
endmodule

module stor_irq_agg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dev_irq,
  input logic       fifo_unf_pulse,
  input logic       fifo_ovf_pulse,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       cpu_irq,
  input logic       dma_req,
  input logic       unf_q,
  input logic       ovf_q,
  input logic       irq_q,
  input logic [7:0] en_q,
  input logic [7:0] stat
);
  wire clr6 = reg_wr && reg_addr == 2'd2 && reg_wdata[6];
  wire clr5 = reg_wr && reg_addr == 2'd2 && reg_wdata[5];

  AST_LINE_TRACK:  assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (irq_q == $past(dev_irq))); // R1
  AST_DMA_SOURCE:  assert property (@(posedge clk) disable iff (!rst_n) dma_req |-> (irq_q && en_q[7])); // R2
  AST_UNF_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) (unf_q && !clr6) |=> unf_q); // R3
  AST_OVF_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) (ovf_q && !clr5) |=> ovf_q); // R3
  AST_EVENT_WINS:  assert property (@(posedge clk) disable iff (!rst_n) (fifo_unf_pulse || fifo_ovf_pulse) |=> ((unf_q || !$past(fifo_unf_pulse)) && (ovf_q || !$past(fifo_ovf_pulse)))); // R5
  AST_NO_ENABLE:   assert property (@(posedge clk) disable iff (!rst_n) (en_q[6:3] == 4'b0000) |=> !cpu_irq); // R6
  AST_RSVD_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) (stat[2:0] == 3'b000) && (en_q[2:0] == 3'b000)); // R8
endmodule

bind stor_irq_agg stor_irq_agg_chk chk_i (.*);

// File: tb/stor_irq_agg_tb_top.sv
`timescale 1ns/1ps
module stor_irq_agg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dev_irq = 1'b0, eng_idle = 1'b1, fifo_ovf_pulse = 1'b0, fifo_unf_pulse = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       cpu_irq, dma_req;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  stor_irq_agg dut_i (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic do_reset(input logic line);
    @(negedge clk); dev_irq = line; eng_idle = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [7:0] en;
    logic d, i, u, o;
    // R9 reset with line high, then low
    do_reset(1'b1);
    rd(2'd0, r); chk("R9 status line high", r, 8'h98);
    rd(2'd1, r); chk("R9 enable", r, 8'h00);
    chk("R9 cpu_irq", {7'b0, cpu_irq}, 8'h00);
    do_reset(1'b0);
    rd(2'd0, r); chk("R9 status line low", r, 8'h10);

    // R8 reserved enable bits, R10 map
    wr(2'd1, 8'hFF);
    rd(2'd1, r); chk("R8 enable reserved", r, 8'hF8);
    rd(2'd2, r); chk("R10 addr2 reads 0", r, 8'h00);
    rd(2'd3, r); chk("R10 addr3 reads 0", r, 8'h00);
    wr(2'd1, 8'h00);

    // Main sweep: R1 R2 R3 R4 R6
    for (int e = 0; e < 32; e++) begin
      for (int c = 0; c < 16; c++) begin
        en = 8'(e << 3);
        {d, i, u, o} = 4'(c);
        wr(2'd1, en);
        wr(2'd2, 8'h60);
        @(negedge clk);
        dev_irq = d; eng_idle = i; fifo_unf_pulse = u; fifo_ovf_pulse = o;
        @(negedge clk);
        fifo_unf_pulse = 1'b0; fifo_ovf_pulse = 1'b0;
        @(negedge clk);
        rd(2'd0, r);
        chk("R1 R3 R4 status sweep", r, {d, u, o, i, d, 3'b000});
        chk("R2 dma_req sweep", {7'b0, dma_req}, {7'b0, d & en[7]});
        chk("R6 cpu_irq sweep", {7'b0, cpu_irq}, {7'b0, |({u, o, i, d} & en[6:3])});
      end
    end

    // R1 R4: clear cannot touch live bits
    @(negedge clk); dev_irq = 1'b1; eng_idle = 1'b1;
    wr(2'd2, 8'hFF);
    rd(2'd0, r); chk("R1 R4 clear ignored by live bits", r, 8'h98);

    // R5 event and clear in the same cycle
    wr(2'd2, 8'h60);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h60;
    fifo_unf_pulse = 1'b1; fifo_ovf_pulse = 1'b1;
    @(negedge clk); reg_wr = 1'b0; fifo_unf_pulse = 1'b0; fifo_ovf_pulse = 1'b0;
    rd(2'd0, r); chk("R5 event wins", r & 8'h60, 8'h60);

    // R7 write to status ignored
    wr(2'd1, 8'h48);
    wr(2'd0, 8'h00);
    rd(2'd0, r); chk("R7 status write ignored", r, 8'hF8);
    rd(2'd1, r); chk("R7 enable unchanged", r, 8'h48);

    // R3 clear only underflow, then overflow
    wr(2'd2, 8'h40);
    rd(2'd0, r); chk("R3 clear underflow only", r, 8'hB8);
    wr(2'd2, 8'h20);
    rd(2'd0, r); chk("R3 clear overflow", r, 8'h98);

    // R2 DMA bit never reaches cpu_irq
    wr(2'd1, 8'h80);
    @(negedge clk);
    chk("R2 dma with bit7 only", {6'b0, dma_req, cpu_irq}, 8'h02);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule